// File: doc/BRIEF.md
# SD Block Gap Pause Controller

This block sits in the data path of an SD/SDIO host and lets software pause a multi-block transfer cleanly between two blocks. Software sets a stop request in a small control register. The controller waits until the data engine reports that the current block has fully finished, including its CRC or status phase. It then enters a paused state, emits a one-cycle gap event and holds the card.

A read transfer is held in one of two ways. If read wait is enabled, the controller drives the read-wait signal on DAT[2]. If it is not, the controller gates the card clock, and while the clock is gated new commands are blocked. A paused write transfer needs no hold. The data engine simply sends nothing more.

To restart, software first clears the stop request and then writes 1 to the continue bit. The controller leaves the paused state. The continue bit clears itself once the data engine reports that the transfer is moving again. In 4-bit bus mode, with the interrupt-at-gap bit set, the card interrupt on DAT[1] is sampled while the transfer sits in the gap.

Top module: `sd_gap_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every control field is 0, `reg_rdata` reads 0x00 and every status output is 0.
- R2: The control byte has stop request at bit 0, continue at bit 1, read-wait enable at bit 2 and interrupt-at-gap enable at bit 3. Bits 7:4 always read 0. Bits 0, 2 and 3 take the written value on a write.
- R3: `paused` rises only on the clock edge that samples `blk_end`=1 while the stop bit is 1 and `xfer_active` is 1. A stop request with no block end never pauses the transfer.
- R4: `blk_gap_evt` is high for exactly the one cycle in which `paused` first reads 1.
- R5: Writing 1 to the continue bit while the stop bit reads 0 sets it, and writing 0 leaves it unchanged. While paused, with continue at 1 and stop at 0, `paused` falls on the next edge.
- R6: While the stop bit currently reads 1, any write to the continue bit is ignored, even one that clears stop in the same write.
- R7: On a read transfer (`xfer_is_read`=1), the continue bit clears on the edge after `dat_active` goes from 0 to 1.
- R8: On a write transfer (`xfer_is_read`=0), the continue bit clears on the edge after `wr_active` goes from 0 to 1. A rise of `dat_active` does not clear it.
- R9: A paused read with read wait enabled drives `dat2_rw`=1 and keeps `clk_stop`=0.
- R10: A paused read with read wait disabled drives `clk_stop`=1 and `cmd_block`=1. A paused write drives neither `clk_stop` nor `dat2_rw`.
- R11: `card_int` is registered. It is 1 one cycle after a cycle in which the transfer is paused, the interrupt-at-gap bit is 1, `bus_4bit` is 1 and `card_dat1` is 0 (active-low interrupt).
- R12: In 1-bit mode (`bus_4bit`=0), `card_int` stays 0 whatever the interrupt-at-gap bit and `card_dat1` are.
- R13: `susp_ok` equals the read-wait enable bit.
- R14: Dropping `xfer_active` clears `paused` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the control byte |
| reg_wdata | input | 8 | Write data for the control byte |
| reg_rdata | output | 8 | Current control byte |
| xfer_active | input | 1 | A multi-block transfer is in progress |
| xfer_is_read | input | 1 | 1 for a read transfer, 0 for a write transfer |
| blk_end | input | 1 | Pulse: the current block including CRC/status is complete |
| dat_active | input | 1 | DAT line active status from the data engine |
| wr_active | input | 1 | Write transfer active status from the data engine |
| bus_4bit | input | 1 | 1 when the bus is in 4-bit mode |
| card_dat1 | input | 1 | Sampled DAT[1] level; low signals a card interrupt |
| blk_gap_evt | output | 1 | One-cycle pulse on entering the block gap |
| paused | output | 1 | The transfer is held at a block gap |
| clk_stop | output | 1 | Gate the card clock |
| dat2_rw | output | 1 | Drive read wait on DAT[2] |
| cmd_block | output | 1 | New commands are not allowed |
| card_int | output | 1 | Card interrupt sampled in the gap |
| susp_ok | output | 1 | Suspend/resume is supported |

## Verification
The directed patterns cover the following cases, and each separates a distinct fault:
- A stop request held with no block end, then a block end with no stop request. Together these separate "pause at the gap" from "pause at once".
- Pausing a read with read wait on, then with read wait off, then pausing a write. This tells the three hold outputs apart.
- Continue writes made while stop is set, including one that clears stop in the same write. These separate the dropped write from a write that is merely delayed.
- Rises of `dat_active` and `wr_active` on both transfer directions. These show which status edge clears the continue bit.
- The interrupt line driven low in 4-bit and in 1-bit mode.

A long stretch of random register writes and status inputs is then compared, every cycle, against a behavioural model.

// File: rtl/sd_gap_pkg.sv
// Package: shared field positions and control-register type for the
// block-gap controller. Assumes an 8-bit control byte.
package sd_gap_pkg;
    localparam int GAP_REG_W   = 8;
    localparam int FLD_STOP    = 0;
    localparam int FLD_CONT    = 1;
    localparam int FLD_RWAIT   = 2;
    localparam int FLD_INTGAP  = 3;
    localparam int FLD_USED    = 4;

    typedef struct packed {
        logic int_gap;
        logic rwait_en;
        logic cont;
        logic stop;
    } gap_ctrl_t;
endpackage

// File: rtl/sd_gap_regs.sv
// Module: control byte of the gap controller.
// Holds stop, continue, read-wait and interrupt-at-gap fields. The continue
// field is set only by a write of 1 while stop currently reads 0. It clears
// itself on the rising edge of the status that matches the transfer
// direction. Assumes the status inputs are already synchronous to clk.
module sd_gap_regs
    import sd_gap_pkg::*;
#(
    parameter int REG_W = GAP_REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             xfer_is_read,
    input  logic             dat_active,
    input  logic             wr_active,
    output gap_ctrl_t        ctrl,
    output logic [REG_W-1:0] rdata
);
    localparam int PAD_W = REG_W - FLD_USED;

    logic dat_prev;
    logic wr_prev;
    logic cont_clr;
    logic cont_set;
    logic unused_hi;

    assign unused_hi = ^wdata[REG_W-1:FLD_USED];

    // Detect the restart edge that matches the transfer direction.
    always_comb begin
        if (xfer_is_read) cont_clr = dat_active & ~dat_prev;
        else              cont_clr = wr_active & ~wr_prev;
    end

    // A continue write counts only while stop currently reads 0.
    assign cont_set = wr_en & ~ctrl.stop & wdata[FLD_CONT];

    // Register the status levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_prev <= 1'b0;
            wr_prev  <= 1'b0;
        end else begin
            dat_prev <= dat_active;
            wr_prev  <= wr_active;
        end
    end

    // Update the control fields from writes and from the hardware auto-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            if (wr_en) begin
                ctrl.stop     <= wdata[FLD_STOP];
                ctrl.rwait_en <= wdata[FLD_RWAIT];
                ctrl.int_gap  <= wdata[FLD_INTGAP];
            end
            if (cont_clr)      ctrl.cont <= 1'b0;
            else if (cont_set) ctrl.cont <= 1'b1;
        end
    end

    // Read-back: reserved upper bits are zero.
    assign rdata = {{PAD_W{1'b0}}, ctrl.int_gap, ctrl.rwait_en, ctrl.cont, ctrl.stop};
endmodule

// File: rtl/sd_gap_pause.sv
// Module: pause state of the transfer.
// Enters the gap when a block completes with stop requested. Leaves it on
// continue with stop clear, or when the transfer ends. Assumes blk_end is
// raised only after the block's CRC or status phase has completed.
module sd_gap_pause (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_active,
    input  logic blk_end,
    input  logic stop_req,
    input  logic cont_req,
    output logic paused,
    output logic gap_evt
);
    // Track the paused state and pulse the gap event on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paused  <= 1'b0;
            gap_evt <= 1'b0;
        end else begin
            gap_evt <= 1'b0;
            if (!xfer_active) begin
                paused <= 1'b0;
            end else if (!paused && blk_end && stop_req) begin
                paused  <= 1'b1;
                gap_evt <= 1'b1;
            end else if (paused && cont_req && !stop_req) begin
                paused <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sd_gap_hold.sv
// Module: holding the card in the gap and sampling the card interrupt.
// A paused read is held either by read wait on DAT[2] or by gating the
// clock. The DAT[1] interrupt is sampled only in 4-bit mode with the
// interrupt-at-gap field set. Assumes card_dat1 is already synchronised.
module sd_gap_hold #(
    parameter int INT_STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic paused,
    input  logic xfer_is_read,
    input  logic rwait_en,
    input  logic int_gap,
    input  logic bus_4bit,
    input  logic card_dat1,
    output logic clk_stop,
    output logic dat2_rw,
    output logic cmd_block,
    output logic card_int
);
    logic                  int_raw;
    logic [INT_STAGES-1:0] int_pipe;

    // Choose the hold method for a paused read.
    always_comb begin
        dat2_rw   = paused & xfer_is_read & rwait_en;
        clk_stop  = paused & xfer_is_read & ~rwait_en;
        cmd_block = clk_stop;
    end

    // Qualify the active-low interrupt level by gap, mode and enable.
    assign int_raw = paused & int_gap & bus_4bit & ~card_dat1;

    // Register the qualified interrupt through the chosen number of stages.
    genvar s;
    generate
        for (s = 0; s < INT_STAGES; s++) begin : g_int
            always_ff @(posedge clk) begin
                if (!rst_n) int_pipe[s] <= 1'b0;
                else        int_pipe[s] <= (s == 0) ? int_raw : int_pipe[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign card_int = int_pipe[INT_STAGES-1];
endmodule

// File: rtl/sd_gap_ctrl.sv
// Module: top of the block-gap pause controller.
// Wires the control byte, the pause state and the hold/interrupt logic.
// Assumes every input is synchronous to clk.
module sd_gap_ctrl
    import sd_gap_pkg::*;
#(
    parameter int REG_W = GAP_REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             xfer_active,
    input  logic             xfer_is_read,
    input  logic             blk_end,
    input  logic             dat_active,
    input  logic             wr_active,
    input  logic             bus_4bit,
    input  logic             card_dat1,
    output logic             blk_gap_evt,
    output logic             paused,
    output logic             clk_stop,
    output logic             dat2_rw,
    output logic             cmd_block,
    output logic             card_int,
    output logic             susp_ok
);
    gap_ctrl_t ctrl;

    sd_gap_regs #(.REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wdata(reg_wdata),
        .xfer_is_read(xfer_is_read), .dat_active(dat_active),
        .wr_active(wr_active), .ctrl(ctrl), .rdata(reg_rdata)
    );

    sd_gap_pause u_pause (
        .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active),
        .blk_end(blk_end), .stop_req(ctrl.stop), .cont_req(ctrl.cont),
        .paused(paused), .gap_evt(blk_gap_evt)
    );

    sd_gap_hold #(.INT_STAGES(1)) u_hold (
        .clk(clk), .rst_n(rst_n), .paused(paused),
        .xfer_is_read(xfer_is_read), .rwait_en(ctrl.rwait_en),
        .int_gap(ctrl.int_gap), .bus_4bit(bus_4bit), .card_dat1(card_dat1),
        .clk_stop(clk_stop), .dat2_rw(dat2_rw), .cmd_block(cmd_block),
        .card_int(card_int)
    );

    // Suspend/resume needs read wait.
    assign susp_ok = ctrl.rwait_en;
endmodule

// File: rtl/sd_gap_ctrl_chk.sv
// Module: property checker for sd_gap_ctrl, attached by bind.
// Observes ports only.
module sd_gap_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] reg_rdata,
    input logic       xfer_active,
    input logic       blk_end,
    input logic       bus_4bit,
    input logic       blk_gap_evt,
    input logic       paused,
    input logic       clk_stop,
    input logic       dat2_rw,
    input logic       card_int,
    input logic       susp_ok
);
    assert_pause_at_block_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paused) |-> $past(blk_end) && $past(reg_rdata[0]));

    assert_evt_on_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paused) |-> blk_gap_evt);

    assert_evt_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        blk_gap_evt |=> !blk_gap_evt);

    assert_cont_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[0] && !reg_rdata[1]) |=> !reg_rdata[1]);

    assert_one_hold_method_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(clk_stop && dat2_rw));

    assert_no_int_1bit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_4bit |=> !card_int);

    assert_susp_follows_rw_R13: assert property (@(posedge clk) disable iff (!rst_n)
        susp_ok == reg_rdata[2]);

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7:4] == 4'h0);

    assert_abort_clears_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active |=> !paused);
endmodule

bind sd_gap_ctrl sd_gap_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .xfer_active(xfer_active),
    .blk_end(blk_end), .bus_4bit(bus_4bit), .blk_gap_evt(blk_gap_evt),
    .paused(paused), .clk_stop(clk_stop), .dat2_rw(dat2_rw),
    .card_int(card_int), .susp_ok(susp_ok)
);

// File: tb/sd_gap_ctrl_tb.sv
module sd_gap_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       xfer_active = 1'b0, xfer_is_read = 1'b0, blk_end = 1'b0;
    logic       dat_active = 1'b0, wr_active = 1'b0, bus_4bit = 1'b0, card_dat1 = 1'b1;
    logic       blk_gap_evt, paused, clk_stop, dat2_rw, cmd_block, card_int, susp_ok;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Behavioural reference state
    bit m_stop, m_cont, m_rw, m_ien, m_paused, m_evt, m_int, m_dprev, m_wprev;

    always #4 clk = ~clk;

    sd_gap_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .xfer_active(xfer_active), .xfer_is_read(xfer_is_read),
        .blk_end(blk_end), .dat_active(dat_active), .wr_active(wr_active),
        .bus_4bit(bus_4bit), .card_dat1(card_dat1), .blk_gap_evt(blk_gap_evt),
        .paused(paused), .clk_stop(clk_stop), .dat2_rw(dat2_rw),
        .cmd_block(cmd_block), .card_int(card_int), .susp_ok(susp_ok)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model advances on each edge; outputs compared 2 ns later.
    always @(posedge clk) begin
        bit n_cont, clr;
        if (!rst_n) begin
            {m_stop, m_cont, m_rw, m_ien, m_paused, m_evt, m_int, m_dprev, m_wprev} = '0;
        end else begin
            clr = xfer_is_read ? (dat_active && !m_dprev) : (wr_active && !m_wprev);
            n_cont = m_cont;
            if (clr) n_cont = 0;
            else if (reg_wr_en && !m_stop && reg_wdata[1]) n_cont = 1;
            m_int = m_paused && m_ien && bus_4bit && !card_dat1;
            m_evt = 0;
            if (!xfer_active) m_paused = 0;
            else if (!m_paused && blk_end && m_stop) begin m_paused = 1; m_evt = 1; end
            else if (m_paused && m_cont && !m_stop) m_paused = 0;
            if (reg_wr_en) begin
                m_stop = reg_wdata[0]; m_rw = reg_wdata[2]; m_ien = reg_wdata[3];
            end
            m_cont = n_cont;
            m_dprev = dat_active;
            m_wprev = wr_active;
            #2;
            if (!done) begin
                chk("R2 rdata", reg_rdata, {4'h0, m_ien, m_rw, m_cont, m_stop});
                chk("R3 paused", paused, m_paused);
                chk("R4 blk_gap_evt", blk_gap_evt, m_evt);
                chk("R9 dat2_rw", dat2_rw, m_paused && xfer_is_read && m_rw);
                chk("R10 clk_stop", clk_stop, m_paused && xfer_is_read && !m_rw);
                chk("R10 cmd_block", cmd_block, m_paused && xfer_is_read && !m_rw);
                chk("R11 card_int", card_int, m_int);
                chk("R13 susp_ok", susp_ok, m_rw);
            end
        end
    end

    task automatic wr(input logic [7:0] d);
        @(negedge clk); reg_wr_en = 1'b1; reg_wdata = d;
        @(negedge clk); reg_wr_en = 1'b0;
    endtask

    task automatic pulse_end();
        @(negedge clk); blk_end = 1'b1;
        @(negedge clk); blk_end = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rdata", reg_rdata, 8'h00);
        chk("R1 outputs", {blk_gap_evt, paused, clk_stop, dat2_rw, cmd_block, card_int, susp_ok}, 8'h00);
        rst_n = 1'b1;
        idle(2);

        // R2: field layout, reserved bits read zero
        wr(8'hFD);
        chk("R2 layout", reg_rdata, 8'h0D);
        wr(8'h00);

        // R3: stop set but no block end -> no pause; block end without stop -> no pause
        xfer_active = 1; xfer_is_read = 1; dat_active = 1;
        wr(8'h05);
        idle(5);
        chk("R3 no pause without block end", paused, 1'b0);
        wr(8'h04);
        pulse_end();
        chk("R3 no pause without stop", paused, 1'b0);

        // R3/R4/R9: pause a read with read wait
        wr(8'h05);
        @(negedge clk); blk_end = 1;
        @(negedge clk); blk_end = 0;
        chk("R4 event on entry", {blk_gap_evt, paused}, 8'h03);
        chk("R9 read wait on DAT2", {clk_stop, dat2_rw}, 8'h01);
        idle(1);
        chk("R4 event one cycle", blk_gap_evt, 1'b0);
        dat_active = 0;

        // R6: continue write dropped while stop is 1 (same write clears stop)
        wr(8'h06);
        chk("R6 continue dropped", reg_rdata, 8'h04);
        idle(2);
        chk("R6 still paused", paused, 1'b1);
        // R5: continue now taken
        wr(8'h06);
        chk("R5 continue set", reg_rdata[1], 1'b1);
        idle(1);
        chk("R5 resumed", paused, 1'b0);
        wr(8'h04);
        chk("R5 write 0 keeps continue", reg_rdata[1], 1'b1);
        // R7: dat_active rise clears continue on a read
        @(negedge clk); dat_active = 1;
        @(negedge clk);
        chk("R7 auto clear on read", reg_rdata[1], 1'b0);

        // R10: read wait off -> clock gated
        wr(8'h01);
        pulse_end();
        chk("R10 clock stop", {clk_stop, dat2_rw, cmd_block}, 8'h05);
        // R14: dropping the transfer clears the pause
        @(negedge clk); xfer_active = 0;
        @(negedge clk);
        chk("R14 abort clears pause", paused, 1'b0);

        // R8/R10: write transfer
        wr(8'h00);
        xfer_active = 1; xfer_is_read = 0; dat_active = 0; wr_active = 1;
        wr(8'h01);
        pulse_end();
        chk("R10 write pause holds nothing", {paused, clk_stop, dat2_rw}, 8'h04);
        wr_active = 0;
        wr(8'h00);
        wr(8'h02);
        idle(1);
        @(negedge clk); dat_active = 1;
        @(negedge clk);
        chk("R8 dat_active ignored on write", reg_rdata[1], 1'b1);
        @(negedge clk); wr_active = 1;
        @(negedge clk);
        chk("R8 auto clear on write", reg_rdata[1], 1'b0);

        // R11/R12: interrupt in the gap
        xfer_is_read = 1; dat_active = 1; bus_4bit = 1;
        wr(8'h0D);
        pulse_end();
        @(negedge clk); card_dat1 = 0;
        @(negedge clk);
        chk("R11 interrupt sampled", card_int, 1'b1);
        @(negedge clk); bus_4bit = 0;
        @(negedge clk);
        chk("R12 no interrupt in 1-bit mode", card_int, 1'b0);
        idle(2);
        chk("R12 still none", card_int, 1'b0);
        card_dat1 = 1;
        wr(8'h00);
        xfer_active = 0;
        idle(2);

        // Random phase compared against the model every cycle
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            reg_wr_en    = ($urandom_range(0, 5) == 0);
            reg_wdata    = 8'($urandom);
            xfer_active  = ($urandom_range(0, 15) != 0);
            xfer_is_read = ($urandom_range(0, 63) == 0) ? ~xfer_is_read : xfer_is_read;
            blk_end      = ($urandom_range(0, 6) == 0);
            dat_active   = ($urandom_range(0, 3) == 0) ? ~dat_active : dat_active;
            wr_active    = ($urandom_range(0, 3) == 0) ? ~wr_active : wr_active;
            bus_4bit     = ($urandom_range(0, 31) == 0) ? ~bus_4bit : bus_4bit;
            card_dat1    = $urandom_range(0, 1) == 1;
        end
        @(negedge clk); reg_wr_en = 0;
        idle(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule